// File: doc/BRIEF.md
# Sequenced Offset Register Loader

This block holds the two 12-bit threshold values that downstream flag logic compares against fill levels. One value marks how close to empty counts as almost empty. The other marks how close to full counts as almost full. Both registers sit on the FIFO's ordinary data bus. A single active-low load strobe decides whether a write-clock edge with write enable low goes to a threshold register or into the FIFO. Threshold accesses follow a fixed alternation: the empty-side register first, then the full-side register, then the empty-side register again.

A read-clock edge with the load strobe low and read enable low returns the register that the read-side sequence points at. The value goes onto the low 12 bits of a registered output word, and the bits above are cleared. Each clock domain keeps its own one-bit sequence toggle. Raising the load strobe partway through a sequence leaves the toggle where it is, so the next load session carries on with the register that comes next. The block also provides the decoded FIFO write and read strobes, so that the FIFO pointers stay still during threshold accesses.

Top module: `offset_loader`

## Requirements
- R1: While rst_n is low, empty_ofs equals EMPTY_DEF, full_ofs equals FULL_DEF and ofs_q is zero. Both sequence toggles point at the empty-side register (toggle value 0).
- R2: On a wclk rising edge with load_n=0 and wr_en_n=0, din is written into the register the write toggle selects (0 = empty_ofs, 1 = full_ofs), and the toggle then inverts. Repeated edges write empty, full, empty, and so on.
- R3: On a wclk edge with load_n=0 and wr_en_n=1, neither register changes and the write toggle keeps its value.
- R4: fifo_wr is high exactly when load_n=1 and wr_en_n=0. In that case, and when load_n=1 and wr_en_n=1, neither register changes.
- R5: The write toggle keeps its position across periods with load_n high, so a later load access continues with the next register in the alternation.
- R6: On an rclk rising edge with load_n=0 and rd_en_n=0, ofs_q takes the register that the read toggle selects (0 = empty_ofs, 1 = full_ofs) in its low 12 bits, with every bit above bit 11 at zero. The read toggle then inverts.
- R7: fifo_rd is high exactly when load_n=1 and rd_en_n=0. On any rclk edge that is not an offset read, ofs_q holds its value and the read toggle does not move.
- R8: The read toggle advances only on offset reads, independent of the write toggle.
- R9: When an offset write and an offset read fall on the same edge, the read returns the register value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| load_n | input | 1 | Active-low strobe that steers accesses to the threshold registers |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| din | input | OW (12) | Low bits of the data bus carrying threshold values |
| fifo_wr | output | 1 | Decoded FIFO write strobe |
| fifo_rd | output | 1 | Decoded FIFO read strobe |
| ofs_q | output | DW (18) | Registered threshold read-back word, upper bits zero |
| empty_ofs | output | OW (12) | Almost-empty threshold value |
| full_ofs | output | OW (12) | Almost-full threshold value |

## Verification
An offset write on wclk and an offset read on rclk can land on the same edge. This may even hit the register that is being overwritten. The bench drives both clocks from one 200 MHz source so that the two edges always coincide. It sweeps every combination of the three strobes, with changing data, in both an ordered and a scrambled order. A same-edge collision passes only if ofs_q shows the value held before the edge while the register itself shows the new data.

// File: rtl/offset_loader_pkg.sv
package offset_loader_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_OFS  = 2'd1,
    OP_FIFO = 2'd2
  } port_op_e;

  // Shared strobe decode for both sides: load_n steers an enabled access.
  function automatic port_op_e decode_op(input logic load_n, input logic en_n);
    if (en_n)        return OP_IDLE;
    else if (load_n) return OP_FIFO;
    else             return OP_OFS;
  endfunction

endpackage

// File: rtl/offset_rst_sync.sv
module offset_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain[STAGES-1];
endmodule

// File: rtl/offset_wr_side.sv
module offset_wr_side
  import offset_loader_pkg::*;
#(
  parameter int          OW        = 12,
  parameter logic [OW-1:0] EMPTY_DEF = '0,
  parameter logic [OW-1:0] FULL_DEF  = '1
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          load_n,
  input  logic          wr_en_n,
  input  logic [OW-1:0] din,
  output logic          fifo_wr,
  output ofs_sel_e      wptr,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs
);
  port_op_e        op;
  ofs_sel_e        wptr_nx;
  logic [OW-1:0]   empty_nx, full_nx;
  logic            empty_ce, full_ce, ptr_ce;

  always_comb begin
    op       = decode_op(load_n, wr_en_n);
    fifo_wr  = (op == OP_FIFO);
    ptr_ce   = (op == OP_OFS);
    empty_ce = ptr_ce && (wptr == SEL_EMPTY);
    full_ce  = ptr_ce && (wptr == SEL_FULL);
    wptr_nx  = (wptr == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    empty_nx = din;
    full_nx  = din;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wptr      <= SEL_EMPTY;
      empty_ofs <= EMPTY_DEF;
      full_ofs  <= FULL_DEF;
    end else begin
      if (ptr_ce)   wptr      <= wptr_nx;
      if (empty_ce) empty_ofs <= empty_nx;
      if (full_ce)  full_ofs  <= full_nx;
    end
  end
endmodule

// File: rtl/offset_rd_side.sv
module offset_rd_side
  import offset_loader_pkg::*;
#(
  parameter int OW = 12,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          load_n,
  input  logic          rd_en_n,
  input  logic [OW-1:0] empty_ofs,
  input  logic [OW-1:0] full_ofs,
  output logic          fifo_rd,
  output ofs_sel_e      rptr,
  output logic [DW-1:0] ofs_q
);
  localparam int PAD = DW - OW;

  port_op_e      op;
  ofs_sel_e      rptr_nx;
  logic          rd_ce;
  logic [DW-1:0] q_nx;

  always_comb begin
    op      = decode_op(load_n, rd_en_n);
    fifo_rd = (op == OP_FIFO);
    rd_ce   = (op == OP_OFS);
    rptr_nx = (rptr == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    q_nx    = {{PAD{1'b0}}, (rptr == SEL_EMPTY) ? empty_ofs : full_ofs};
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rptr  <= SEL_EMPTY;
      ofs_q <= '0;
    end else if (rd_ce) begin
      rptr  <= rptr_nx;
      ofs_q <= q_nx;
    end
  end
endmodule

// File: rtl/offset_loader.sv
module offset_loader
  import offset_loader_pkg::*;
#(
  parameter int            OW        = 12,
  parameter int            DW        = 18,
  parameter logic [OW-1:0] EMPTY_DEF = 12'h007,
  parameter logic [OW-1:0] FULL_DEF  = 12'h3F8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  input  logic [OW-1:0] din,
  output logic          fifo_wr,
  output logic          fifo_rd,
  output logic [DW-1:0] ofs_q,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs
);
  logic     wrst_n_s, rrst_n_s;
  ofs_sel_e wptr, rptr;

  offset_rst_sync #(.STAGES(2)) u_wrst (.clk(wclk), .rst_n(rst_n), .rst_n_s(wrst_n_s));
  offset_rst_sync #(.STAGES(2)) u_rrst (.clk(rclk), .rst_n(rst_n), .rst_n_s(rrst_n_s));

  offset_wr_side #(.OW(OW), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)) u_wr (
    .clk(wclk), .rst_n_s(wrst_n_s), .load_n(load_n), .wr_en_n(wr_en_n), .din(din),
    .fifo_wr(fifo_wr), .wptr(wptr), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  offset_rd_side #(.OW(OW), .DW(DW)) u_rd (
    .clk(rclk), .rst_n_s(rrst_n_s), .load_n(load_n), .rd_en_n(rd_en_n),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .fifo_rd(fifo_rd), .rptr(rptr), .ofs_q(ofs_q)
  );
endmodule

// File: rtl/offset_loader_chk.sv
module offset_loader_chk #(
  parameter int OW = 12,
  parameter int DW = 18
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n_s,
  input logic          rrst_n_s,
  input logic          load_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic [OW-1:0] din,
  input logic          fifo_wr,
  input logic          wptr,
  input logic          rptr,
  input logic [DW-1:0] ofs_q,
  input logic [OW-1:0] empty_ofs,
  input logic [OW-1:0] full_ofs
);
  p_write_lands_r2: assert property (@(posedge wclk) disable iff (!wrst_n_s)
    (!load_n && !wr_en_n) |=> (($past(wptr) ? full_ofs : empty_ofs) == $past(din)));

  p_write_toggles_r2: assert property (@(posedge wclk) disable iff (!wrst_n_s)
    (!load_n && !wr_en_n) |=> (wptr != $past(wptr)));

  p_nop_holds_r3: assert property (@(posedge wclk) disable iff (!wrst_n_s)
    (!load_n && wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr)));

  p_fifo_wr_keeps_regs_r4: assert property (@(posedge wclk) disable iff (!wrst_n_s)
    fifo_wr |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr)));

  p_read_value_r6: assert property (@(posedge rclk) disable iff (!rrst_n_s)
    (!load_n && !rd_en_n) |=>
      (ofs_q == {{(DW-OW){1'b0}}, ($past(rptr) ? $past(full_ofs) : $past(empty_ofs))}));

  p_q_holds_r7: assert property (@(posedge rclk) disable iff (!rrst_n_s)
    !(!load_n && !rd_en_n) |=> ($stable(ofs_q) && $stable(rptr)));
endmodule

bind offset_loader offset_loader_chk #(.OW(OW), .DW(DW)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n_s(wrst_n_s), .rrst_n_s(rrst_n_s),
  .load_n(load_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .din(din),
  .fifo_wr(fifo_wr), .wptr(wptr), .rptr(rptr), .ofs_q(ofs_q),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/offset_loader_tb_top.sv
module offset_loader_tb_top;
  localparam int            OW = 12;
  localparam int            DW = 18;
  localparam logic [OW-1:0] E_DEF = 12'h007;
  localparam logic [OW-1:0] F_DEF = 12'h3F8;

  logic clk = 1'b0;
  logic rst_n, load_n, wr_en_n, rd_en_n;
  logic [OW-1:0] din;
  logic fifo_wr, fifo_rd;
  logic [DW-1:0] ofs_q;
  logic [OW-1:0] empty_ofs, full_ofs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model
  logic [OW-1:0] m_emp, m_ful;
  logic [DW-1:0] m_q;
  logic          m_wp, m_rp;
  logic [17:0]   lfsr = 18'h2A5C3;

  always #2.5 clk = ~clk;

  offset_loader #(.OW(OW), .DW(DW), .EMPTY_DEF(E_DEF), .FULL_DEF(F_DEF)) dut_i (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(load_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .din(din), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .ofs_q(ofs_q), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
  endtask

  // Drive one vector at a falling edge, check decodes, then check state a full cycle later.
  task automatic apply(input logic ld, input logic wn, input logic rn, input logic [OW-1:0] d);
    logic wr_op, rd_op;
    load_n = ld; wr_en_n = wn; rd_en_n = rn; din = d;
    #1;
    chk("R4 fifo_wr decode", {17'b0, fifo_wr}, {17'b0, ld & ~wn});
    chk("R7 fifo_rd decode", {17'b0, fifo_rd}, {17'b0, ld & ~rn});
    wr_op = !ld && !wn;
    rd_op = !ld && !rn;
    // R9: the read takes the pre-edge register contents
    if (rd_op) begin
      m_q  = {{(DW-OW){1'b0}}, m_rp ? m_ful : m_emp};
      m_rp = ~m_rp;
    end
    if (wr_op) begin
      if (m_wp) m_ful = d; else m_emp = d;
      m_wp = ~m_wp;
    end
    @(negedge clk);
    if (wr_op) begin
      chk("R2 empty_ofs after load write", {6'b0, empty_ofs}, {6'b0, m_emp});
      chk("R2 full_ofs after load write", {6'b0, full_ofs}, {6'b0, m_ful});
    end else if (!ld) begin
      chk("R3 empty_ofs on load no-op", {6'b0, empty_ofs}, {6'b0, m_emp});
      chk("R3 full_ofs on load no-op", {6'b0, full_ofs}, {6'b0, m_ful});
    end else begin
      chk("R4 R5 empty_ofs with load_n high", {6'b0, empty_ofs}, {6'b0, m_emp});
      chk("R4 R5 full_ofs with load_n high", {6'b0, full_ofs}, {6'b0, m_ful});
    end
    if (rd_op && wr_op) chk("R9 same-edge read returns old value", ofs_q, m_q);
    else if (rd_op)     chk("R6 R8 offset read value", ofs_q, m_q);
    else                chk("R7 ofs_q holds", ofs_q, m_q);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0; din = 12'hABC;
    repeat (4) @(negedge clk);
    chk("R1 empty_ofs reset", {6'b0, empty_ofs}, {6'b0, E_DEF});
    chk("R1 full_ofs reset", {6'b0, full_ofs}, {6'b0, F_DEF});
    chk("R1 ofs_q reset", ofs_q, '0);
    load_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_emp = E_DEF; m_ful = F_DEF; m_q = '0; m_wp = 1'b0; m_rp = 1'b0;
    // R1 pointers: the first reads return the empty then the full default
    apply(1'b0, 1'b1, 1'b0, 12'h000);
    apply(1'b0, 1'b1, 1'b0, 12'h000);
    // R5: one write, leave load mode, return: the next write goes to full
    apply(1'b0, 1'b0, 1'b1, 12'h123);
    apply(1'b1, 1'b0, 1'b1, 12'hFFF);
    apply(1'b1, 1'b1, 1'b1, 12'hEEE);
    apply(1'b0, 1'b0, 1'b1, 12'h456);
    // Ordered sweep over all strobe combinations
    for (int i = 0; i < 256; i++) begin
      step_lfsr();
      apply(i[2], i[1], i[0], lfsr[OW-1:0]);
    end
    // Scrambled sweep
    for (int i = 0; i < 1024; i++) begin
      step_lfsr();
      apply(lfsr[15], lfsr[13], lfsr[16], lfsr[OW-1:0] ^ 12'h5A5);
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule